// File: doc/BRIEF.md
# Grouped Vector Unsigned Maximum Unit

This execution unit holds a file of 32 vector registers, each `VL` bits wide. One command names a lane width, a destination group of two or four consecutive, aligned registers, and one shared register. For every register in the group, the unit takes the lane-wise unsigned maximum of that register and the shared register. The result replaces the group register. All lanes are updated, because the operation has no predicate.

The unit handles one register per cycle. It first reads and computes every group register into a private buffer. It then writes the buffer back one register per cycle. Because no write happens until all computation is finished, a shared register that falls inside the group is read with its original contents on every step.

Two enable inputs gate execution. When the multi-vector feature is off, the command is refused and an undefined-command flag pulses. When the feature is on but streaming mode is off, the command is refused and a trap flag pulses. A debug read port and a preload write port give direct access to the register file.

Top module: `vmax_group_unit`

## Requirements
- R1: `cmd_size` selects the lane width as 8 shifted left by `cmd_size` (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit lanes). Each result lane is the larger of the two lanes, with both lanes read as unsigned integers.
- R2: With `cmd_quad` = 0, the group is registers 2*`cmd_grp` and 2*`cmd_grp`+1, using all 4 bits of `cmd_grp`.
- R3: With `cmd_quad` = 1, the group is registers 4*`cmd_grp[2:0]` through 4*`cmd_grp[2:0]`+3, and `cmd_grp[3]` has no effect.
- R4: The shared operand is register `cmd_shr` (0 to 15). The same register is used for every member of the group.
- R5: If the shared register lies inside the group, every result is computed from the original contents of the shared register.
- R6: Every lane of every group register is overwritten. Registers outside the group keep their contents.
- R7: An accepted command with `feat_en` = 0 changes no register and never sets `busy`. `undef_flag` is high for exactly the one cycle after acceptance, and `trap_flag` stays low. This check takes priority over the R8 check.
- R8: An accepted command with `feat_en` = 1 and `strm_en` = 0 changes no register and never sets `busy`. `trap_flag` is high for exactly the one cycle after acceptance, and `undef_flag` stays low.
- R9: An executed command holds `busy` high for 2*N cycles after the accepting edge, where N is the group size. `done` pulses for one cycle as `busy` falls. `cmd_valid` has no effect while `busy` is high.
- R10: `dbg_rdata` always shows register `dbg_raddr`. A preload write with `pre_we` = 1 takes effect at the next edge while the unit is idle, and has no effect while `busy` is high.
- R11: After reset, `busy`, `done`, `undef_flag` and `trap_flag` are 0, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; accepted when idle |
| cmd_size | input | 2 | Lane width code |
| cmd_grp | input | 4 | Group field (bit 3 unused in 4-register form) |
| cmd_shr | input | 4 | Shared operand register index |
| cmd_quad | input | 1 | 1 = four-register group, 0 = two-register group |
| feat_en | input | 1 | Multi-vector feature enable |
| strm_en | input | 1 | Streaming mode enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| undef_flag | output | 1 | One-cycle pulse: refused, feature disabled |
| trap_flag | output | 1 | One-cycle pulse: refused, streaming disabled |
| dbg_raddr | input | 5 | Debug read register index |
| dbg_rdata | output | VL | Debug read data |
| pre_we | input | 1 | Preload write enable |
| pre_waddr | input | 5 | Preload register index |
| pre_wdata | input | VL | Preload data |

## Verification
On every cycle, the assertions check the timing and control rules. They confirm that `done` is a single pulse that never overlaps `busy`, that each refused command gives exactly one flag of the right kind and never starts the unit, and that the latched command fields and lane size stay fixed while a command runs. Only the bench scenarios can show the data results. The bench sweeps every lane width, both group forms and every legal group position, with shared registers inside and outside the group. After each command it compares the whole register file against an arithmetic model. The same scenarios show that commands and preloads issued during a busy period leave no trace.

// File: rtl/vmax_pkg.sv
package vmax_pkg;
  localparam int GRP_MAX = 4;
  localparam int NUM_SIZES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COMP = 2'd1,
    ST_WB   = 2'd2
  } vmax_state_e;

  // last group index for a 2- or 4-register group
  function automatic logic [1:0] last_index(input logic quad);
    return quad ? 2'(GRP_MAX - 1) : 2'(GRP_MAX / 2 - 1);
  endfunction
endpackage

// File: rtl/vmax_regfile.sv
module vmax_regfile #(
  parameter int VL    = 128,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [VL-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [VL-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [VL-1:0] rb_data,
  input  logic [AW-1:0] rd_addr,
  output logic [VL-1:0] rd_data
);
  logic [VL-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
  assign rd_data = regs[rd_addr];
endmodule

// File: rtl/vmax_lanes.sv
module vmax_lanes #(
  parameter int VL = 128
) (
  input  logic [1:0]    size,
  input  logic [VL-1:0] a,
  input  logic [VL-1:0] b,
  output logic [VL-1:0] y
);
  logic [VL-1:0] by_width [vmax_pkg::NUM_SIZES];

  for (genvar gw = 0; gw < vmax_pkg::NUM_SIZES; gw++) begin : g_width
    localparam int W  = 8 << gw;
    localparam int LN = VL / W;
    for (genvar l = 0; l < LN; l++) begin : g_lane
      logic [W-1:0] la, lb;
      assign la = a[l*W +: W];
      assign lb = b[l*W +: W];
      assign by_width[gw][l*W +: W] = (la > lb) ? la : lb;
    end
  end

  assign y = by_width[size];
endmodule

// File: rtl/vmax_ctrl.sv
module vmax_ctrl #(
  parameter int AW = 5,
  localparam int GW = AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_size,
  input  logic [GW-1:0] cmd_grp,
  input  logic [GW-1:0] cmd_shr,
  input  logic          cmd_quad,
  input  logic          feat_en,
  input  logic          strm_en,
  output logic          busy,
  output logic          done,
  output logic          undef_flag,
  output logic          trap_flag,
  output logic [1:0]    op_size,
  output logic [AW-1:0] grp_addr,
  output logic [AW-1:0] shr_addr,
  output logic          buf_we,
  output logic          wb_en,
  output logic [1:0]    step
);
  import vmax_pkg::*;

  vmax_state_e   state;
  logic [1:0]    idx;
  logic [AW-1:0] base_q;
  logic [GW-1:0] shr_q;
  logic          quad_q;
  logic [1:0]    size_q;

  logic          accept, go, last;
  logic [AW-1:0] base_n;

  assign accept = cmd_valid && (state == ST_IDLE);
  assign go     = accept && feat_en && strm_en;
  assign last   = (idx == last_index(quad_q));
  assign base_n = cmd_quad ? {cmd_grp[GW-2:0], 2'b00} : {cmd_grp, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx        <= '0;
      base_q     <= '0;
      shr_q      <= '0;
      quad_q     <= 1'b0;
      size_q     <= '0;
      done       <= 1'b0;
      undef_flag <= 1'b0;
      trap_flag  <= 1'b0;
    end else begin
      done       <= 1'b0;
      undef_flag <= accept && !feat_en;
      trap_flag  <= accept && feat_en && !strm_en;
      case (state)
        ST_IDLE: if (go) begin
          state  <= ST_COMP;
          idx    <= '0;
          base_q <= base_n;
          shr_q  <= cmd_shr;
          quad_q <= cmd_quad;
          size_q <= cmd_size;
        end
        ST_COMP: begin
          idx <= last ? 2'd0 : idx + 2'd1;
          if (last) state <= ST_WB;
        end
        ST_WB: begin
          idx <= last ? 2'd0 : idx + 2'd1;
          if (last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign buf_we   = (state == ST_COMP);
  assign wb_en    = (state == ST_WB);
  assign step     = idx;
  assign op_size  = size_q;
  assign grp_addr = base_q + AW'(idx);
  assign shr_addr = {1'b0, shr_q};

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  undef_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !feat_en) |=> (undef_flag && !trap_flag && !busy));
  // R8
  trap_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && feat_en && !strm_en) |=> (trap_flag && !undef_flag && !busy));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(base_q) && $stable(shr_q) && $stable(quad_q)));
  // R1
  size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_size));
endmodule

// File: rtl/vmax_group_unit.sv
module vmax_group_unit #(
  parameter int VL    = 128,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_size,
  input  logic [AW-2:0] cmd_grp,
  input  logic [AW-2:0] cmd_shr,
  input  logic          cmd_quad,
  input  logic          feat_en,
  input  logic          strm_en,
  output logic          busy,
  output logic          done,
  output logic          undef_flag,
  output logic          trap_flag,
  input  logic [AW-1:0] dbg_raddr,
  output logic [VL-1:0] dbg_rdata,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_waddr,
  input  logic [VL-1:0] pre_wdata
);
  logic [1:0]    op_size, step;
  logic [AW-1:0] grp_addr, shr_addr;
  logic          buf_we, wb_en;
  logic [VL-1:0] grp_data, shr_data, max_data;
  logic [VL-1:0] res_buf [vmax_pkg::GRP_MAX];

  logic          rf_we;
  logic [AW-1:0] rf_waddr;
  logic [VL-1:0] rf_wdata;

  vmax_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_size(cmd_size),
    .cmd_grp(cmd_grp), .cmd_shr(cmd_shr), .cmd_quad(cmd_quad),
    .feat_en(feat_en), .strm_en(strm_en), .busy(busy), .done(done),
    .undef_flag(undef_flag), .trap_flag(trap_flag), .op_size(op_size),
    .grp_addr(grp_addr), .shr_addr(shr_addr), .buf_we(buf_we),
    .wb_en(wb_en), .step(step)
  );

  vmax_lanes #(.VL(VL)) u_lanes (
    .size(op_size), .a(grp_data), .b(shr_data), .y(max_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < vmax_pkg::GRP_MAX; i++) res_buf[i] <= '0;
    end else if (buf_we) begin
      res_buf[step] <= max_data;
    end
  end

  assign rf_we    = wb_en || (pre_we && !busy);
  assign rf_waddr = wb_en ? grp_addr : pre_waddr;
  assign rf_wdata = wb_en ? res_buf[step] : pre_wdata;

  vmax_regfile #(.VL(VL), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_addr(grp_addr), .ra_data(grp_data),
    .rb_addr(shr_addr), .rb_data(shr_data),
    .rd_addr(dbg_raddr), .rd_data(dbg_rdata)
  );
endmodule

// File: tb/vmax_group_unit_test.sv
`timescale 1ns/1ps
module vmax_group_unit_test;
  localparam int VL = 128;
  localparam int NR = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_quad = 0, feat_en = 1, strm_en = 1, pre_we = 0;
  logic [1:0] cmd_size = 0;
  logic [3:0] cmd_grp = 0, cmd_shr = 0;
  logic [4:0] dbg_raddr = 0, pre_waddr = 0;
  logic [VL-1:0] pre_wdata = '0, dbg_rdata;
  logic busy, done, undef_flag, trap_flag;

  int n_chk = 0, n_bad = 0;
  logic [VL-1:0] model [NR];

  always #2.5 clk = ~clk;

  vmax_group_unit #(.VL(VL), .NREGS(NR)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_size(cmd_size),
    .cmd_grp(cmd_grp), .cmd_shr(cmd_shr), .cmd_quad(cmd_quad),
    .feat_en(feat_en), .strm_en(strm_en), .busy(busy), .done(done),
    .undef_flag(undef_flag), .trap_flag(trap_flag), .dbg_raddr(dbg_raddr),
    .dbg_rdata(dbg_rdata), .pre_we(pre_we), .pre_waddr(pre_waddr),
    .pre_wdata(pre_wdata)
  );

  task automatic check(input logic ok, input string req, input logic [VL-1:0] act,
                       input logic [VL-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VL-1:0] pattern(input int r, input int seed);
    logic [VL-1:0] v;
    for (int k = 0; k < VL / 32; k++) begin
      logic [31:0] w;
      w = (r * 32'h9E3779B1) ^ (seed * 32'h85EBCA77) ^ ((k + 1) * 32'hC2B2AE3D);
      w = w ^ (w >> 13) ^ (w << 7);
      v[k*32 +: 32] = w;
    end
    if ((r + seed) % 7 == 0) v = '1;
    if ((r + seed) % 11 == 0) v = '0;
    return v;
  endfunction

  function automatic logic [VL-1:0] ref_max(input logic [VL-1:0] a, input logic [VL-1:0] b,
                                            input int sz);
    logic [VL-1:0] r, msk, xa, xb;
    int w;
    w = 8 * (1 << sz);
    msk = (VL'(1) << w) - VL'(1);
    r = '0;
    for (int i = 0; i < VL / w; i++) begin
      xa = (a >> (i * w)) & msk;
      xb = (b >> (i * w)) & msk;
      r = r | ((xa > xb ? xa : xb) << (i * w));
    end
    return r;
  endfunction

  task automatic preload_all(input int seed);
    for (int r = 0; r < NR; r++) begin
      @(negedge clk);
      pre_we = 1; pre_waddr = 5'(r); pre_wdata = pattern(r, seed);
      model[r] = pattern(r, seed);
    end
    @(negedge clk);
    pre_we = 0;
  endtask

  task automatic compare_all(input string req);
    for (int r = 0; r < NR; r++) begin
      dbg_raddr = 5'(r);
      #0.1;
      check(dbg_rdata === model[r], req, dbg_rdata, model[r]);
    end
  endtask

  // R1 R2 R3 R4 R5 R6 R9 R10: run one executed command and predict everything
  task automatic run_cmd(input logic quad, input logic [3:0] grp, input logic [3:0] shr,
                         input int sz);
    int base, n, junk_addr;
    logic [VL-1:0] tmp [4];
    n = quad ? 4 : 2;
    base = quad ? 4 * int'(grp[2:0]) : 2 * int'(grp);
    for (int r = 0; r < n; r++) tmp[r] = ref_max(model[base + r], model[shr], sz);
    for (int r = 0; r < n; r++) model[base + r] = tmp[r];
    junk_addr = (base + 16) % NR;
    @(negedge clk);
    cmd_valid = 1; cmd_quad = quad; cmd_grp = grp; cmd_shr = shr; cmd_size = 2'(sz);
    @(negedge clk);
    // R9: command presented while busy, must be ignored
    cmd_grp = grp ^ 4'h1; cmd_shr = shr ^ 4'h5; cmd_size = 2'(sz + 1);
    pre_we = 1; pre_waddr = 5'(junk_addr); pre_wdata = '1;
    for (int k = 0; k < 2 * n; k++) begin
      check(busy === 1'b1 && done === 1'b0, "R9 busy window", VL'({busy, done}), VL'(2'b10));
      if (k == 0) begin
        @(negedge clk);
        cmd_valid = 0; pre_we = 0;
      end else begin
        @(negedge clk);
      end
    end
    check(busy === 1'b0 && done === 1'b1, "R9 done pulse", VL'({busy, done}), VL'(2'b01));
    @(negedge clk);
    check(done === 1'b0, "R9 done single", VL'(done), VL'(0));
    compare_all(quad ? "R3 R1 R5 R6 R10 group result" : "R2 R1 R5 R6 R10 group result");
  endtask

  task automatic refused(input logic fe, input logic se);
    @(negedge clk);
    feat_en = fe; strm_en = se;
    cmd_valid = 1; cmd_quad = 1; cmd_grp = 4'h2; cmd_shr = 4'h3; cmd_size = 2'd0;
    @(negedge clk);
    cmd_valid = 0;
    if (!fe) begin
      // R7
      check(undef_flag === 1 && trap_flag === 0 && busy === 0, "R7 undef pulse",
            VL'({undef_flag, trap_flag, busy}), VL'(3'b100));
    end else begin
      // R8
      check(trap_flag === 1 && undef_flag === 0 && busy === 0, "R8 trap pulse",
            VL'({undef_flag, trap_flag, busy}), VL'(3'b010));
    end
    @(negedge clk);
    check(undef_flag === 0 && trap_flag === 0 && busy === 0, "R7 R8 flag single",
          VL'({undef_flag, trap_flag, busy}), VL'(0));
    compare_all(fe ? "R8 no change" : "R7 no change");
    feat_en = 1; strm_en = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    // R11
    check(busy === 0 && done === 0 && undef_flag === 0 && trap_flag === 0,
          "R11 reset outputs", VL'({busy, done, undef_flag, trap_flag}), VL'(0));
    rst_n = 1;
    @(negedge clk);
    compare_all("R11 reset registers");
    preload_all(1);
    compare_all("R10 preload");

    // exhaustive sweep of sizes, forms and groups
    for (int s = 0; s < 4; s++) begin
      for (int q = 0; q < 2; q++) begin
        for (int g = 0; g < (q ? 8 : 16); g++) begin
          logic [3:0] gf, sh;
          preload_all(s * 97 + q * 31 + g);
          // R3: bit 3 of group field toggled in 4-register form
          gf = q ? {g[0], g[2:0]} : 4'(g);
          sh = 4'((g * 5 + s * 3 + q) & 15);
          run_cmd(q[0], gf, sh, s);
        end
      end
    end

    // R5: shared register equals first and last group member
    preload_all(500);
    run_cmd(1'b1, 4'h1, 4'h4, 0);
    run_cmd(1'b1, 4'h1, 4'h7, 3);
    run_cmd(1'b0, 4'h7, 4'hF, 1);

    refused(1'b0, 1'b1);
    refused(1'b0, 1'b0);
    refused(1'b1, 1'b0);

    // unit still works after refusals
    run_cmd(1'b0, 4'h3, 4'h0, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule